// File: doc/BRIEF.md
# Systematic Hamming 15-11 codec

A purely combinational single-error-correcting codec for an 11-bit data word. The encoder half takes an 11-bit data word and returns a 15-bit codeword. The data is carried through unchanged in the low eleven bits. Four parity bits, each formed by a fixed XOR over seven of the data bits, sit in the top nibble.

The decoder half accepts a 15-bit codeword that may have been corrupted in one position. It recomputes the four parity bits from the received data field and XORs them with the received parity nibble to form a syndrome. It then repairs the damage:

- A syndrome that matches the parity-membership pattern of a data bit flips that data bit.
- A syndrome with exactly one bit set points at a damaged parity bit, so the data is left alone.

The decoder reports the corrected data, the syndrome, and an error flag. The two halves are independent and can sit at the two ends of a storage or link path.

Top module: `hamming15_11_codec`

## Requirements
- R1: The encoder copies its data input unchanged into codeword bits 10:0 (bit i of the data into bit i of the codeword).
- R2: Codeword bits 11, 12, 13 and 14 hold parity p0, p1, p2 and p3 respectively. p0 = XOR of data bits {0,1,3,4,6,8,10}. p1 = XOR of {0,2,3,5,6,9,10}. p2 = XOR of {1,2,3,7,8,9,10}. p3 = XOR of {4,5,6,7,8,9,10}.
- R3: The decoder syndrome equals the parity recomputed from received bits 10:0, XORed with received bits 14:11. Syndrome bit i corresponds to p_i.
- R4: When the syndrome is zero, the decoded data equals received bits 10:0 and the error flag is 0.
- R5: A single flipped data bit i is corrected, and the syndrome equals that bit's membership column {p3,p2,p1,p0}. The columns are, for bits 0..10: 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15.
- R6: A single flipped parity bit i gives the syndrome 1<<i and leaves the decoded data equal to received bits 10:0.
- R7: The error flag is 1 exactly when the syndrome is nonzero.
- R8: Every one of the 2048 data values, encoded and then decoded without damage, returns the original data with a zero syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | 11 | Data word to encode |
| enc_code_o | output | 15 | Codeword {p3,p2,p1,p0,data} |
| dec_code_i | input | 15 | Received codeword to decode |
| dec_data_o | output | 11 | Corrected data word |
| dec_syndrome_o | output | 4 | Syndrome, bit i for parity p_i |
| dec_error_o | output | 1 | High when the syndrome is nonzero |

## Verification
The bench goes after the single-bit error position in all fifteen places, because a wrong membership column would leave one data bit uncorrected or flip a neighbour instead. The four parity-bit positions matter most: a decoder that treated a one-hot syndrome as a data fix would corrupt clean data. An exhaustive round-trip over all 2048 values catches any mistake in a parity equation, and such a mistake would show up as a spurious nonzero syndrome on undamaged words. Hand-worked vectors with all ones and isolated high bits confirm the nibble order, since swapping p0 and p3 would still round-trip but would produce the wrong codeword.

// File: rtl/hamming15_11_codec.sv
module hamming15_11_codec (
  input  logic [10:0] enc_data_i,
  output logic [14:0] enc_code_o,
  input  logic [14:0] dec_code_i,
  output logic [10:0] dec_data_o,
  output logic [3:0]  dec_syndrome_o,
  output logic        dec_error_o
);
  localparam logic [10:0] M0 = 11'h55B;
  localparam logic [10:0] M1 = 11'h66D;
  localparam logic [10:0] M2 = 11'h78E;
  localparam logic [10:0] M3 = 11'h7F0;

  function automatic logic [3:0] par_of(input logic [10:0] d);
    par_of = {^(d & M3), ^(d & M2), ^(d & M1), ^(d & M0)};
  endfunction

  logic [10:0] fix;

  assign enc_code_o     = {par_of(enc_data_i), enc_data_i};
  assign dec_syndrome_o = par_of(dec_code_i[10:0]) ^ dec_code_i[14:11];
  assign dec_error_o    = |dec_syndrome_o;

  for (genvar i = 0; i < 11; i++) begin : g_fix
    assign fix[i] = (dec_syndrome_o == {M3[i], M2[i], M1[i], M0[i]});
  end

  assign dec_data_o = dec_code_i[10:0] ^ fix;
endmodule

module hamming15_11_codec_chk (
  input logic [10:0] enc_data_i,
  input logic [14:0] enc_code_o,
  input logic [14:0] dec_code_i,
  input logic [10:0] dec_data_o,
  input logic [3:0]  dec_syndrome_o,
  input logic        dec_error_o
);
  always_comb begin
    if (dec_code_i == enc_code_o) begin
      // R8
      rt_clean_chk: assert (dec_data_o == enc_data_i && !dec_error_o)
        else $error("loopback mismatch");
    end
    if (!dec_error_o) begin
      // R4
      pass_chk: assert (dec_data_o == dec_code_i[10:0])
        else $error("clean word altered");
    end
    if ($onehot(dec_syndrome_o)) begin
      // R6
      par_err_chk: assert (dec_data_o == dec_code_i[10:0] && dec_error_o)
        else $error("parity error touched data");
    end
    if ($countones(dec_syndrome_o) > 1) begin
      // R5
      data_fix_chk: assert ($countones(dec_data_o ^ dec_code_i[10:0]) == 1)
        else $error("data fix not single bit");
    end
  end
endmodule

bind hamming15_11_codec hamming15_11_codec_chk chk_i (
  .enc_data_i(enc_data_i), .enc_code_o(enc_code_o), .dec_code_i(dec_code_i),
  .dec_data_o(dec_data_o), .dec_syndrome_o(dec_syndrome_o), .dec_error_o(dec_error_o)
);

// File: tb/hamming15_11_codec_tb.sv
module hamming15_11_codec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [10:0] enc_data_i;
  logic [14:0] enc_code_o;
  logic [14:0] dec_code_i;
  logic [10:0] dec_data_o;
  logic [3:0]  dec_syndrome_o;
  logic        dec_error_o;

  hamming15_11_codec dut_i (
    .enc_data_i(enc_data_i), .enc_code_o(enc_code_o), .dec_code_i(dec_code_i),
    .dec_data_o(dec_data_o), .dec_syndrome_o(dec_syndrome_o), .dec_error_o(dec_error_o)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // {data, expected codeword}, worked by hand from R1/R2
  localparam logic [25:0] VEC [5] = '{
    {11'h000, 15'h0000},
    {11'h7FF, 15'h7FFF},
    {11'h001, 15'h1801},
    {11'h400, 15'h7C00},
    {11'h214, 15'h0A14}
  };

  function automatic logic [3:0] col(input int j);
    case (j)
      0: col = 4'd3;   1: col = 4'd5;   2: col = 4'd6;   3: col = 4'd7;
      4: col = 4'd9;   5: col = 4'd10;  6: col = 4'd11;  7: col = 4'd12;
      8: col = 4'd13;  9: col = 4'd14;  default: col = 4'd15;
    endcase
  endfunction

  function automatic logic [14:0] model_enc(input logic [10:0] d);
    logic [3:0] p = 4'd0;
    for (int j = 0; j < 11; j++) if (d[j]) p ^= col(j);
    return {p, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    enc_data_i = '0;
    dec_code_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rst", {17'd0, enc_code_o}, 32'd0);
    check("R4 rst", {21'd0, dec_data_o}, 32'd0);
    check("R7 rst", {31'd0, dec_error_o}, 32'd0);

    for (int v = 0; v < 5; v++) begin
      @(posedge clk);
      enc_data_i = VEC[v][25:15];
      dec_code_i = VEC[v][14:0];
      @(negedge clk);
      check("R2 vec", {17'd0, enc_code_o}, {17'd0, VEC[v][14:0]});
      check("R3 vec", {28'd0, dec_syndrome_o}, 32'd0);
    end

    for (int d = 0; d < 2048; d++) begin
      @(posedge clk);
      enc_data_i = 11'(d);
      dec_code_i = model_enc(11'(d));
      @(negedge clk);
      check("R1", {21'd0, enc_code_o[10:0]}, d);
      check("R2", {17'd0, enc_code_o}, {17'd0, model_enc(11'(d))});
      check("R8", {16'd0, dec_error_o, dec_syndrome_o, dec_data_o}, d);
    end

    for (int t = 0; t < 40; t++) begin
      logic [10:0] d = 11'($urandom);
      for (int j = 0; j < 15; j++) begin
        @(posedge clk);
        enc_data_i = d;
        dec_code_i = model_enc(d) ^ (15'd1 << j);
        @(negedge clk);
        if (j < 11) begin
          check("R5 data", {21'd0, dec_data_o}, {21'd0, d});
          check("R5 syn", {28'd0, dec_syndrome_o}, {28'd0, col(j)});
        end else begin
          check("R6 data", {21'd0, dec_data_o}, {21'd0, d});
          check("R6 syn", {28'd0, dec_syndrome_o}, 32'd1 << (j - 11));
        end
        check("R7", {31'd0, dec_error_o}, 32'd1);
      end
    end

    @(posedge clk);
    dec_code_i = 15'h0000 ^ (15'd1 << 14);
    @(negedge clk);
    check("R3 p3", {28'd0, dec_syndrome_o}, 32'd8);
    check("R4 p3", {21'd0, dec_data_o}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule